// File: doc/BRIEF.md
# Paired-Result Conversion Sequencer

This block controls one external 10-bit analog converter and makes it look like two independent converters to the rest of the chip. Each accepted trigger causes two conversions in a row. The first uses the channel programmed for logical unit A, and the second uses the channel programmed for logical unit B. Each channel is one of eight multiplexer inputs. Each result goes into its own small result queue, one queue per logical unit. When a full queue receives a new result, the oldest entry is discarded.

Configuration is written to a staging copy at any time. A bit in the written word decides how the staging copy reaches the live configuration:
- it can replace the live configuration at once, abandoning any conversion in flight, or
- it can wait until the current pair finishes.

Three trigger sources can start a pair, each with its own enable: a software strobe, a synchronised rising edge on an external pin, and an internal event strobe. Continuous operation re-launches pairs back to back without a trigger. Single operation raises a sticky completion flag, which drives an interrupt line when enabled.

The converter handshake is a one-cycle start pulse plus a 3-bit channel number. Completion comes in one of two ways:
- a fixed count of 17 prescaled clock ticks, with the data bus sampled at the end of the count, or
- a done strobe that qualifies the data bus.

Top module: `adc_pair_sequencer`

## Requirements
- R1: After reset no conversion is running, `cnv_start` is low, both queues are empty, and `irq_flag` and `irq` are low.
- R2: The configuration word holds unit A's channel in bits 2:0 and unit B's channel in bits 5:3. Within a pair, the first start pulse carries unit A's channel and the second carries unit B's channel. `cnv_chan` holds steady while a conversion is in progress.
- R3: With the done strobe disabled (bit 12 = 0), each conversion lasts exactly 17 × (P + 1) clocks, where P is the prescale field in bits 16:13. This is the spacing between consecutive start pulses, and `cnv_start` is high for one clock only.
- R4: The first result of a pair enters queue A (`res_a`) and the second enters queue B (`res_b`). Each queue shows its oldest entry and a non-empty bit. A `rd_pop` bit removes that entry; a pop on an empty queue is ignored.
- R5: A queue holds FIFO_DEPTH (2) results. A result written into a full queue evicts the oldest one.
- R6: A trigger source starts a pair only when its enable bit is set: software `sw_go` bit 8, external pin bit 9, internal `evt_trig` bit 10. A strobe from a disabled source starts nothing.
- R7: The external pin passes through two synchroniser flops and acts on its rising edge only. A pin held high starts exactly one pair.
- R8: Triggers arriving while a pair is in progress are ignored.
- R9: In single mode (bit 6 = 0), the end of a pair sets `irq_flag`. The flag stays set until `flag_clr` is pulsed. `irq` is high only when the flag is set and bit 11 is 1.
- R10: In continuous mode (bit 6 = 1), a new pair starts right after each pair ends, and `irq_flag` is not set. Continuous operation stops at the end of the pair during which a word with bit 6 = 0 was staged.
- R11: A word written with bit 7 = 0 takes effect only when the current pair ends (or within one clock when idle). The pair in progress keeps its original channels.
- R12: A word written with bit 7 = 1 takes effect on the next clock and abandons the conversion in progress. No result of the abandoned conversion is queued, and no further start pulse follows.
- R13: With bit 12 = 1, a conversion ends when `cnv_done` is high (ignored in the start-pulse cycle). The value on `cnv_data` in that cycle is queued, and the next start pulse follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the configuration word |
| ctl_wdata | input | 17 | Configuration word (layout in R2, R3, R6, R9–R13) |
| sw_go | input | 1 | Software trigger strobe |
| ext_soc | input | 1 | Asynchronous external trigger pin |
| evt_trig | input | 1 | Internal event trigger strobe |
| flag_clr | input | 1 | Clears the completion flag |
| rd_pop | input | 2 | Pop strobes, bit 0 queue A, bit 1 queue B |
| cnv_done | input | 1 | Converter completion strobe |
| cnv_data | input | 10 | Converter result bus |
| cnv_start | output | 1 | One-clock conversion start pulse |
| cnv_chan | output | 3 | Channel number for the converter multiplexer |
| res_a | output | 10 | Oldest entry of queue A |
| res_b | output | 10 | Oldest entry of queue B |
| nonempty | output | 2 | Queue non-empty bits, bit 0 A, bit 1 B |
| busy | output | 1 | A conversion pair is in progress |
| irq_flag | output | 1 | Sticky pair-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the converter model keeps `cnv_data` steady from a start pulse until its conversion ends. They also assume the converter never returns a done strobe in the same cycle as the start pulse; the design also ignores one there.

The stimulus drives every input half a cycle away from the active edge. It issues configuration writes and pops only as single-cycle strobes. It draws prescale values and channels from a fixed-seed random stream, keeping the prescale small enough that each pair fits well within the run. The model raises its done strobe five cycles after each start when done mode is selected.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;

   localparam int CH_W        = 3;
   localparam int PRE_W       = 4;
   localparam int NUM_LOGICAL = 2;

   typedef struct packed {
      logic [PRE_W-1:0] prescale;   // divide by prescale+1
      logic             use_done;   // end conversion on done strobe
      logic             irq_en;
      logic             en_evt;
      logic             en_pin;
      logic             en_sw;
      logic             load_now;   // apply immediately, aborting
      logic             cont;       // continuous pairs
      logic [CH_W-1:0]  ch_b;
      logic [CH_W-1:0]  ch_a;
   } seq_cfg_t;

   localparam int CFG_W = $bits(seq_cfg_t);

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         run,
   input  logic [W-1:0] div_m1,
   output logic         tick
);

   logic [W-1:0] cnt_q;

   assign tick = run && (cnt_q == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear || !run)  cnt_q <= '0;
      else if (tick)           cnt_q <= '0;
      else                     cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              nonempty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("adc_result_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [CNT_W-1:0]  cnt_q, cnt_d;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
      cnt_d = cnt_q;
      if (pop && cnt_q != '0) begin
         for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i + 1];
         cnt_d = cnt_q - CNT_W'(1);
      end
      if (push) begin
         if (cnt_d == CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_d[i + 1];
            mem_d[DEPTH-1] = din;
         end else begin
            for (int i = 0; i < DEPTH; i++)
               if (i == int'(cnt_d)) mem_d[i] = din;
            cnt_d = cnt_d + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      end
   end

   assign dout     = mem_q[0];
   assign nonempty = (cnt_q != '0);

endmodule

// File: rtl/adc_pair_fsm.sv
module adc_pair_fsm
   import adc_pair_pkg::*;
#(
   parameter int CONV_TICKS = 17,
   localparam int TCNT_W    = $clog2(CONV_TICKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   trig,
   input  logic                   abort,
   input  logic                   use_done,
   input  logic                   cont_next,
   input  logic [CH_W-1:0]        ch_a,
   input  logic [CH_W-1:0]        ch_b,
   input  logic                   tick,
   input  logic                   cnv_done,
   output logic                   busy,
   output logic                   cnv_start,
   output logic [CH_W-1:0]        cnv_chan,
   output logic                   launch,
   output logic [NUM_LOGICAL-1:0] push,
   output logic                   pair_done
);

   logic              busy_q, idx_q, kick_q;
   logic [TCNT_W-1:0] tcnt_q;
   logic              conv_end;

   always_comb begin
      if (use_done) conv_end = busy_q && cnv_done && !kick_q;
      else          conv_end = busy_q && tick && (tcnt_q == TCNT_W'(CONV_TICKS - 1));
      launch    = !abort && ((!busy_q && trig) || (conv_end && (!idx_q || cont_next)));
      pair_done = !abort && conv_end && idx_q;
      push      = '0;
      if (conv_end && !abort) push[idx_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= 1'b0;
         kick_q <= 1'b0;
         tcnt_q <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         idx_q  <= 1'b0;
         kick_q <= 1'b0;
         tcnt_q <= '0;
      end else if (launch) begin
         busy_q <= 1'b1;
         kick_q <= 1'b1;
         tcnt_q <= '0;
         idx_q  <= busy_q & ~idx_q;
      end else if (conv_end) begin
         busy_q <= 1'b0;
         kick_q <= 1'b0;
         idx_q  <= 1'b0;
         tcnt_q <= '0;
      end else begin
         kick_q <= 1'b0;
         if (tick && busy_q) tcnt_q <= tcnt_q + TCNT_W'(1);
      end
   end

   assign busy      = busy_q;
   assign cnv_start = kick_q;
   assign cnv_chan  = idx_q ? ch_b : ch_a;

endmodule

// File: rtl/adc_pair_sequencer.sv
module adc_pair_sequencer
   import adc_pair_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int FIFO_DEPTH  = 2,
   parameter int CONV_TICKS  = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctl_wr,
   input  logic [CFG_W-1:0]       ctl_wdata,
   input  logic                   sw_go,
   input  logic                   ext_soc,
   input  logic                   evt_trig,
   input  logic                   flag_clr,
   input  logic [NUM_LOGICAL-1:0] rd_pop,
   input  logic                   cnv_done,
   input  logic [DATA_W-1:0]      cnv_data,
   output logic                   cnv_start,
   output logic [CH_W-1:0]        cnv_chan,
   output logic [DATA_W-1:0]      res_a,
   output logic [DATA_W-1:0]      res_b,
   output logic [NUM_LOGICAL-1:0] nonempty,
   output logic                   busy,
   output logic                   irq_flag,
   output logic                   irq
);

   if (CONV_TICKS < 2)   begin : g_bad_ticks $error("CONV_TICKS must be at least 2"); end
   if (SYNC_STAGES < 2)  begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (NUM_LOGICAL != 2) begin : g_bad_units $error("two logical units expected"); end

   seq_cfg_t shadow_q, active_q, wr_cfg;
   logic     abort, trig_any, pin_rise, tick, launch, pair_done, flag_q;
   logic [NUM_LOGICAL-1:0] push_v;
   logic [SYNC_STAGES:0]   pin_sync_q;
   logic [DATA_W-1:0]      head [NUM_LOGICAL];

   assign wr_cfg = seq_cfg_t'(ctl_wdata);
   assign abort  = ctl_wr && wr_cfg.load_now;

   // staging and live configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
      end else begin
         if (ctl_wr) shadow_q <= wr_cfg;
         if (abort)                    active_q <= wr_cfg;
         else if (!busy || pair_done)  active_q <= shadow_q;
      end
   end

   // external pin synchroniser and edge detect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_sync_q <= '0;
      else        pin_sync_q <= {pin_sync_q[SYNC_STAGES-1:0], ext_soc};
   end
   assign pin_rise = pin_sync_q[SYNC_STAGES-1] & ~pin_sync_q[SYNC_STAGES];

   assign trig_any = (active_q.en_sw  && sw_go)
                   | (active_q.en_pin && pin_rise)
                   | (active_q.en_evt && evt_trig);

   adc_prescaler #(.W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (launch),
      .run    (busy),
      .div_m1 (active_q.prescale),
      .tick   (tick)
   );

   adc_pair_fsm #(.CONV_TICKS(CONV_TICKS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig_any),
      .abort     (abort),
      .use_done  (active_q.use_done),
      .cont_next (shadow_q.cont),
      .ch_a      (active_q.ch_a),
      .ch_b      (active_q.ch_b),
      .tick      (tick),
      .cnv_done  (cnv_done),
      .busy      (busy),
      .cnv_start (cnv_start),
      .cnv_chan  (cnv_chan),
      .launch    (launch),
      .push      (push_v),
      .pair_done (pair_done)
   );

   for (genvar g = 0; g < NUM_LOGICAL; g++) begin : g_unit
      adc_result_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_v[g]),
         .pop      (rd_pop[g]),
         .din      (cnv_data),
         .dout     (head[g]),
         .nonempty (nonempty[g])
      );
   end

   assign res_a = head[0];
   assign res_b = head[1];

   // completion flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           flag_q <= 1'b0;
      else if (pair_done && !active_q.cont) flag_q <= 1'b1;
      else if (flag_clr)                    flag_q <= 1'b0;
   end

   assign irq_flag = flag_q;
   assign irq      = flag_q && active_q.irq_en;

endmodule

// File: rtl/adc_pair_sequencer_chk.sv
module adc_pair_sequencer_chk #(
   parameter int CH_W = 3,
   parameter int NL   = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cnv_start,
   input logic [CH_W-1:0] cnv_chan,
   input logic            busy,
   input logic            irq_flag,
   input logic            irq,
   input logic            flag_clr,
   input logic [NL-1:0]   nonempty,
   input logic [NL-1:0]   rd_pop
);

   assert_start_in_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> busy);

   assert_start_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |=> !cnv_start);

   assert_chan_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !cnv_start) |-> $stable(cnv_chan));

   assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_flag);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);

   assert_empty_by_pop_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nonempty[0]) |-> $past(rd_pop[0]));

   assert_empty_by_pop_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nonempty[1]) |-> $past(rd_pop[1]));

endmodule

bind adc_pair_sequencer adc_pair_sequencer_chk #(.CH_W(3), .NL(2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnv_start (cnv_start),
   .cnv_chan  (cnv_chan),
   .busy      (busy),
   .irq_flag  (irq_flag),
   .irq       (irq),
   .flag_clr  (flag_clr),
   .nonempty  (nonempty),
   .rd_pop    (rd_pop)
);

// File: tb/adc_pair_sequencer_test.sv
module adc_pair_sequencer_test;

   localparam int DW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [16:0]   ctl_wdata = '0;
   logic          sw_go = 1'b0, ext_soc = 1'b0, evt_trig = 1'b0, flag_clr = 1'b0;
   logic [1:0]    rd_pop = '0;
   logic          cnv_done = 1'b0;
   logic [DW-1:0] cnv_data = '0;
   logic          cnv_start, busy, irq_flag, irq;
   logic [2:0]    cnv_chan;
   logic [DW-1:0] res_a, res_b;
   logic [1:0]    nonempty;

   int checks = 0, fails = 0, cyc = 0, start_n = 0, done_cd = 0;
   int st_ch  [0:511];
   int st_cyc [0:511];
   bit bdone = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   adc_pair_sequencer uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .sw_go(sw_go), .ext_soc(ext_soc), .evt_trig(evt_trig), .flag_clr(flag_clr),
      .rd_pop(rd_pop), .cnv_done(cnv_done), .cnv_data(cnv_data),
      .cnv_start(cnv_start), .cnv_chan(cnv_chan), .res_a(res_a), .res_b(res_b),
      .nonempty(nonempty), .busy(busy), .irq_flag(irq_flag), .irq(irq)
   );

   function automatic logic [DW-1:0] dat(int n, int ch);
      return DW'(((n % 128) * 8) + ch);
   endfunction

   function automatic logic [16:0] mk(int a, int b, bit cont, bit now, bit sw, bit pin,
                                      bit evt, bit ie, bit ud, int pre);
      return {4'(pre), ud, ie, evt, pin, sw, now, cont, 3'(b), 3'(a)};
   endfunction

   // converter model
   always @(negedge clk) begin
      cyc = cyc + 1;
      cnv_done = 1'b0;
      if (done_cd > 0) begin
         done_cd = done_cd - 1;
         if (done_cd == 0) cnv_done = 1'b1;
      end
      if (cnv_start) begin
         st_ch[start_n % 512]  = int'(cnv_chan);
         st_cyc[start_n % 512] = cyc;
         cnv_data = dat(start_n, int'(cnv_chan));
         start_n  = start_n + 1;
         if (bdone) done_cd = 5;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished && cyc > 150000) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic idle(int n); repeat (n) @(negedge clk); endtask

   task automatic wr(logic [16:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic go_sw();  @(negedge clk); sw_go = 1'b1;    @(negedge clk); sw_go = 1'b0;    endtask
   task automatic go_evt(); @(negedge clk); evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0; endtask
   task automatic clr();    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; endtask

   task automatic wait_idle();
      int k = 0;
      @(negedge clk);
      while (busy && k < 5000) begin @(negedge clk); k++; end
   endtask

   task automatic pop(int g, logic [DW-1:0] exp, string tag);
      logic [DW-1:0] v;
      @(negedge clk);
      v = (g == 0) ? res_a : res_b;
      chk(nonempty[g] && v == exp, tag, int'(v), int'(exp));
      rd_pop[g] = 1'b1;
      @(negedge clk); rd_pop = '0;
   endtask

   task automatic drain();
      repeat (4) begin @(negedge clk); rd_pop = nonempty; end
      @(negedge clk); rd_pop = '0;
   endtask

   initial begin
      int b, p, a, c;
      void'($urandom(32'd7319));
      idle(3);
      chk(!busy && !cnv_start && nonempty == 2'b00 && !irq_flag && !irq, "R1 reset state", int'(busy), 0);
      rst_n = 1'b1;
      idle(2);
      chk(!busy && !cnv_start && nonempty == 2'b00 && !irq_flag && !irq, "R1 after release", int'(nonempty), 0);

      // random single pairs
      for (int it = 0; it < 10; it++) begin
         p = int'($urandom_range(3, 0));
         a = int'($urandom_range(7, 0));
         c = int'($urandom_range(7, 0));
         wr(mk(a, c, 0, 0, 1, 0, 0, 0, 0, p));
         idle(2);
         b = start_n;
         go_sw();
         wait_idle();
         chk(start_n == b + 2, "R2 two starts", start_n - b, 2);
         chk(st_ch[b % 512] == a, "R2 first channel", st_ch[b % 512], a);
         chk(st_ch[(b + 1) % 512] == c, "R2 second channel", st_ch[(b + 1) % 512], c);
         chk(st_cyc[(b + 1) % 512] - st_cyc[b % 512] == 17 * (p + 1), "R3 conversion length",
             st_cyc[(b + 1) % 512] - st_cyc[b % 512], 17 * (p + 1));
         pop(0, dat(b, a), "R4 queue A");
         pop(1, dat(b + 1, c), "R4 queue B");
         chk(nonempty == 2'b00, "R4 empty after pop", int'(nonempty), 0);
         chk(irq_flag && !irq, "R9 flag set, irq masked", int'(irq), 0);
         clr();
         chk(!irq_flag, "R9 flag cleared", int'(irq_flag), 0);
      end

      // R5 overflow and ignored pop on empty
      wr(mk(2, 6, 0, 0, 1, 0, 0, 0, 0, 0));
      idle(2);
      b = start_n;
      repeat (3) begin go_sw(); wait_idle(); end
      pop(0, dat(b + 2, 2), "R5 oldest evicted A");
      pop(0, dat(b + 4, 2), "R5 newest kept A");
      pop(1, dat(b + 3, 6), "R5 oldest evicted B");
      pop(1, dat(b + 5, 6), "R5 newest kept B");
      @(negedge clk); rd_pop = 2'b11; @(negedge clk); rd_pop = '0;
      go_sw(); wait_idle();
      pop(0, dat(b + 6, 2), "R4 pop on empty ignored");
      drain(); clr();

      // R6 source enables
      wr(mk(1, 3, 0, 0, 0, 0, 0, 0, 0, 0));
      idle(2);
      b = start_n;
      go_sw(); go_evt(); idle(40);
      chk(start_n == b && nonempty == 2'b00, "R6 disabled sources ignored", start_n - b, 0);
      wr(mk(1, 3, 0, 0, 0, 0, 1, 0, 0, 0));
      idle(2);
      go_evt(); wait_idle();
      chk(start_n == b + 2, "R6 event source", start_n - b, 2);
      drain(); clr();

      // R7 pin rising edge, held high
      wr(mk(4, 5, 0, 0, 0, 1, 0, 0, 0, 0));
      idle(2);
      b = start_n;
      @(negedge clk); ext_soc = 1'b1;
      idle(6); wait_idle(); idle(30);
      chk(start_n == b + 2, "R7 held pin starts one pair", start_n - b, 2);
      ext_soc = 1'b0; idle(10);
      chk(start_n == b + 2, "R7 falling edge ignored", start_n - b, 2);
      drain(); clr();

      // R8 triggers while busy
      wr(mk(0, 7, 0, 0, 1, 0, 0, 0, 0, 3));
      idle(2);
      b = start_n;
      go_sw(); idle(20); go_sw(); idle(60); go_sw();
      wait_idle(); idle(20);
      chk(start_n == b + 2, "R8 busy triggers ignored", start_n - b, 2);
      drain(); clr();

      // R9 enabled interrupt
      wr(mk(3, 1, 0, 0, 1, 0, 0, 1, 0, 0));
      idle(2);
      chk(!irq, "R9 irq low before pair", int'(irq), 0);
      go_sw(); wait_idle(); idle(1);
      chk(irq && irq_flag, "R9 irq raised", int'(irq), 1);
      idle(5);
      chk(irq_flag, "R9 flag sticky", int'(irq_flag), 1);
      clr();
      chk(!irq && !irq_flag, "R9 irq cleared", int'(irq), 0);
      drain();

      // R10 continuous
      wr(mk(6, 2, 1, 0, 1, 0, 0, 1, 0, 0));
      idle(2);
      b = start_n;
      go_sw(); idle(34 * 3 + 10);
      chk(start_n >= b + 6 && busy, "R10 continuous restarts", start_n - b, 6);
      chk(st_cyc[(b + 2) % 512] - st_cyc[(b + 1) % 512] == 17, "R10 back-to-back spacing",
          st_cyc[(b + 2) % 512] - st_cyc[(b + 1) % 512], 17);
      chk(!irq_flag, "R10 no flag in continuous", int'(irq_flag), 0);
      wr(mk(6, 2, 0, 0, 1, 0, 0, 1, 0, 0));
      wait_idle(); idle(20);
      c = start_n;
      idle(40);
      chk(!busy && start_n == c && ((start_n - b) % 2) == 0, "R10 stops at pair end", start_n - c, 0);
      drain(); clr();

      // R11 deferred load
      wr(mk(1, 2, 0, 0, 1, 0, 0, 0, 0, 3));
      idle(2);
      b = start_n;
      go_sw(); idle(10);
      wr(mk(5, 6, 0, 0, 1, 0, 0, 0, 0, 3));
      wait_idle();
      chk(st_ch[b % 512] == 1 && st_ch[(b + 1) % 512] == 2, "R11 pair keeps old channels",
          st_ch[(b + 1) % 512], 2);
      go_sw(); wait_idle();
      chk(st_ch[(b + 2) % 512] == 5 && st_ch[(b + 3) % 512] == 6, "R11 next pair new channels",
          st_ch[(b + 3) % 512], 6);
      drain(); clr();

      // R12 immediate load aborts
      wr(mk(0, 1, 0, 0, 1, 0, 0, 0, 0, 7));
      idle(2);
      b = start_n;
      go_sw(); idle(10);
      wr(mk(4, 7, 0, 1, 1, 0, 0, 0, 0, 0));
      chk(!busy, "R12 abort stops pair", int'(busy), 0);
      idle(300);
      chk(start_n == b + 1 && nonempty == 2'b00, "R12 nothing queued", int'(nonempty), 0);
      go_sw(); wait_idle();
      chk(st_ch[(b + 1) % 512] == 4 && st_ch[(b + 2) % 512] == 7, "R12 new config live",
          st_ch[(b + 1) % 512], 4);
      drain(); clr();

      // R13 done-strobe mode
      bdone = 1'b1;
      wr(mk(2, 3, 0, 0, 1, 0, 0, 0, 1, 7));
      idle(2);
      b = start_n;
      go_sw(); wait_idle();
      chk(st_cyc[(b + 1) % 512] - st_cyc[b % 512] == 6, "R13 ends on done strobe",
          st_cyc[(b + 1) % 512] - st_cyc[b % 512], 6);
      pop(0, dat(b, 2), "R13 data A");
      pop(1, dat(b + 1, 3), "R13 data B");
      bdone = 1'b0;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule